// File: doc/BRIEF.md
# Pulse-Width Qualified Activity Detector

This block turns a raw one-bit activity indication (already thresholded upstream, high meaning "signal above threshold") into a clean presence flag. The indication is sampled on a fast clock through a synchronizer. A continuous high run must reach an accept length before presence is raised, so short noise bursts are discarded. Once presence is raised, it is held by a release timer. Each qualifying high run on the line restarts that timer, and presence drops when the timer runs out.

After presence drops, an optional hold-off window blocks any new assertion for a fixed number of sample cycles. Every limit is a parameter in sample-clock counts. The same module can therefore serve as a receive-carrier qualifier (with hold-off) and as a collision qualifier (hold-off set to zero). The defaults are the carrier profile at a 200 MHz sample rate: reject 4, accept 9, release 32, hold-off 24.

The parameters must satisfy `1 <= REJECT_W < ACCEPT_W` and `SYNC_STAGES >= 2`. Edge numbers below count rising clock edges. Edge 0 is the first edge at which `lineIn` is sampled high.

Top module: `activity_qualifier`

## Requirements
- R1: The synchronous reset `rst` forces `present` low and clears the synchronizer, the run counter, the release timer and the hold-off timer. The first qualifying run after reset is therefore never blocked by a stale hold-off.
- R2: When `lineIn` stays low for at least RELEASE_W+SYNC_STAGES+1 consecutive edges, `present` is low.
- R3: A high run of fewer than ACCEPT_W consecutive samples never raises `present`. This includes runs at or above REJECT_W but below ACCEPT_W.
- R4: A run of at least ACCEPT_W high samples raises `present` ACCEPT_W+SYNC_STAGES edges after its first high sample, provided hold-off is not active.
- R5: `present` falls RELEASE_W edges after the most recent restart of the release timer. The timer restarts in two cases: at the edge that raises `present`, and, while `present` is high, at the edge where a high run reaches REJECT_W samples. That edge is REJECT_W+SYNC_STAGES-1 edges after the run's first high sample.
- R6: While `present` is high, a high run shorter than REJECT_W samples does not restart the release timer.
- R7: For HOLDOFF_W edges after the edge at which `present` falls, `present` cannot be raised again. The earliest re-assertion is HOLDOFF_W+1 edges after that fall edge.
- R8: A run that has reached ACCEPT_W samples and is still high when hold-off expires raises `present` at the first edge where hold-off allows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lineIn | input | 1 | Asynchronous thresholded activity bit |
| present | output | 1 | Qualified presence flag, registered |

## Verification
Each result has its own due edge, counted from the first edge that samples the line high:
- a qualifying run raises `present` after edge ACCEPT_W+2;
- a retrigger lands at edge REJECT_W+1 of its run, and presence falls RELEASE_W edges after the latest restart;
- a re-assertion blocked by hold-off lands exactly HOLDOFF_W+1 edges after the fall.

The bench drives `lineIn` on falling edges from a per-edge pattern. It then records the exact edge index at which `present` first rises and falls, and compares those indices against the formulas above. Off-by-one errors in any counter or in the synchronizer depth therefore appear as wrong edge numbers, not just as wrong levels.

// File: rtl/actq_pkg.sv
`timescale 1ns/1ps
package actq_pkg;

  // Strobes from the control FSM to the datapath counters
  typedef struct packed {
    logic loadRel;   // (re)start release timer
    logic decRel;    // count release timer down
    logic clrRel;    // release timer expired, clear it
    logic loadHold;  // start post-release hold-off
  } actqCtrl_t;

  // Status returned by the datapath
  typedef struct packed {
    logic qualHit;   // current high run reaches the reject width this cycle
    logic acceptLvl; // current high run has reached the accept width
    logic relLast;   // release timer on its final count
    logic holdBusy;  // hold-off window still open
  } actqStat_t;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } actqState_t;

endpackage

// File: rtl/actq_datapath.sv
`timescale 1ns/1ps
module actq_datapath
  import actq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REJECT_W    = 4,
  parameter int ACCEPT_W    = 9,
  parameter int RELEASE_W   = 32,
  parameter int HOLDOFF_W   = 24
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      lineIn,
  input  actqCtrl_t ctrl,
  output actqStat_t stat
);

  localparam int RUN_W = $clog2(ACCEPT_W + 1);
  localparam int REL_W = $clog2(RELEASE_W + 1);

  // Synchronizer chain for the asynchronous line bit
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineQ;

  always_ff @(posedge clk) begin
    if (rst) syncQ <= '0;
    else     syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
  end
  assign lineQ = syncQ[SYNC_STAGES-1];

  // Run-length counter of consecutive high samples, saturating at accept
  logic [RUN_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (rst)                               runCnt <= '0;
    else if (!lineQ)                       runCnt <= '0;
    else if (runCnt != RUN_W'(ACCEPT_W))   runCnt <= runCnt + 1'b1;
  end

  assign stat.qualHit   = lineQ && (runCnt == RUN_W'(REJECT_W - 1));
  assign stat.acceptLvl = (runCnt == RUN_W'(ACCEPT_W));

  // Release timer
  logic [REL_W-1:0] relCnt;

  always_ff @(posedge clk) begin
    if (rst)               relCnt <= '0;
    else if (ctrl.loadRel) relCnt <= REL_W'(RELEASE_W);
    else if (ctrl.clrRel)  relCnt <= '0;
    else if (ctrl.decRel)  relCnt <= relCnt - 1'b1;
  end

  assign stat.relLast = (relCnt == REL_W'(1));

  // Hold-off timer, present only when the window is non-zero
  generate
    if (HOLDOFF_W > 0) begin : g_hold
      localparam int HOLD_W = $clog2(HOLDOFF_W + 1);
      logic [HOLD_W-1:0] holdCnt;

      always_ff @(posedge clk) begin
        if (rst)                holdCnt <= '0;
        else if (ctrl.loadHold) holdCnt <= HOLD_W'(HOLDOFF_W);
        else if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
      end

      assign stat.holdBusy = (holdCnt != '0);
    end else begin : g_noHold
      logic unusedHoldStrobe;
      assign unusedHoldStrobe = ctrl.loadHold;
      assign stat.holdBusy    = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/actq_control.sv
`timescale 1ns/1ps
module actq_control
  import actq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  actqStat_t stat,
  output actqCtrl_t ctrl,
  output logic      present
);

  actqState_t state;
  actqState_t stateNext;
  logic       canAssert;

  assign canAssert = stat.acceptLvl && !stat.holdBusy;

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (canAssert) begin
          ctrl.loadRel = 1'b1;
          stateNext    = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (stat.qualHit) begin
          ctrl.loadRel = 1'b1;
        end else if (stat.relLast) begin
          ctrl.clrRel   = 1'b1;
          ctrl.loadHold = 1'b1;
          stateNext     = ST_IDLE;
        end else begin
          ctrl.decRel = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign present = (state == ST_ACTIVE);

endmodule

// File: rtl/activity_qualifier.sv
`timescale 1ns/1ps
module activity_qualifier
  import actq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REJECT_W    = 4,
  parameter int ACCEPT_W    = 9,
  parameter int RELEASE_W   = 32,
  parameter int HOLDOFF_W   = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic lineIn,
  output logic present
);

  actqCtrl_t ctrl;
  actqStat_t stat;

  actq_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .REJECT_W   (REJECT_W),
    .ACCEPT_W   (ACCEPT_W),
    .RELEASE_W  (RELEASE_W),
    .HOLDOFF_W  (HOLDOFF_W)
  ) u_datapath (
    .clk   (clk),
    .rst   (rst),
    .lineIn(lineIn),
    .ctrl  (ctrl),
    .stat  (stat)
  );

  actq_control u_control (
    .clk    (clk),
    .rst    (rst),
    .stat   (stat),
    .ctrl   (ctrl),
    .present(present)
  );

endmodule

// File: rtl/actq_checker.sv
`timescale 1ns/1ps
module actq_checker #(
  parameter int SYNC_STAGES = 2,
  parameter int ACCEPT_W    = 9,
  parameter int RELEASE_W   = 32,
  parameter int HOLDOFF_W   = 24
) (
  input logic clk,
  input logic rst,
  input logic lineIn,
  input logic present
);

  localparam int HI_W    = $clog2(ACCEPT_W + 1);
  localparam int LOW_MAX = RELEASE_W + SYNC_STAGES + 1;
  localparam int LOW_W   = $clog2(LOW_MAX + 1);
  localparam int ON_W    = $clog2(RELEASE_W + 1);
  localparam int OFF_W   = (HOLDOFF_W > 0) ? $clog2(HOLDOFF_W + 1) : 1;

  logic [HI_W-1:0]  hiRun;
  logic [LOW_W-1:0] lowRun;
  logic [ON_W-1:0]  onCnt;
  logic [OFF_W-1:0] offCnt;
  logic             qualSeen;

  always_ff @(posedge clk) begin
    if (rst) begin
      hiRun    <= '0;
      lowRun   <= '0;
      onCnt    <= ON_W'(RELEASE_W);
      offCnt   <= OFF_W'(HOLDOFF_W);
      qualSeen <= 1'b0;
    end else begin
      if (!lineIn)                         hiRun <= '0;
      else if (hiRun != HI_W'(ACCEPT_W))   hiRun <= hiRun + 1'b1;

      if (lineIn)                          lowRun <= '0;
      else if (lowRun != LOW_W'(LOW_MAX))  lowRun <= lowRun + 1'b1;

      if (!present)                        onCnt <= '0;
      else if (onCnt != ON_W'(RELEASE_W))  onCnt <= onCnt + 1'b1;

      if (present)                         offCnt <= '0;
      else if (offCnt != OFF_W'(HOLDOFF_W)) offCnt <= offCnt + 1'b1;

      if (hiRun == HI_W'(ACCEPT_W))        qualSeen <= 1'b1;
      else if (present)                    qualSeen <= 1'b0;
    end
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (int'(lowRun) >= LOW_MAX) |-> !present); // R2

  AST_RISE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(present) |-> qualSeen); // R3

  AST_MIN_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(present) |-> (int'(onCnt) >= RELEASE_W - 1)); // R5

  AST_HOLDOFF_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(present) |-> (int'(offCnt) >= HOLDOFF_W)); // R7

  AST_NO_REASSERT_NEXT: assert property (@(posedge clk) disable iff (rst)
    ((HOLDOFF_W > 0) && $fell(present)) |=> !present); // R7

endmodule

bind activity_qualifier actq_checker #(
  .SYNC_STAGES(SYNC_STAGES),
  .ACCEPT_W   (ACCEPT_W),
  .RELEASE_W  (RELEASE_W),
  .HOLDOFF_W  (HOLDOFF_W)
) u_actqChecker (
  .clk    (clk),
  .rst    (rst),
  .lineIn (lineIn),
  .present(present)
);

// File: tb/test_activity_qualifier.sv
`timescale 1ns/1ps
module test_activity_qualifier;

  localparam int REJ  = 4;
  localparam int ACC  = 9;
  localparam int REL  = 32;
  localparam int HOLD = 24;
  localparam int SYNC = 2;

  // Edge index (first high sample = edge 1) at which present is first seen high
  localparam int RISE_N = ACC + SYNC + 1;
  localparam int FALL_N = RISE_N + REL;

  // {pulse width, expect assertion}
  localparam int NVEC = 9;
  localparam int VEC [NVEC][2] = '{
    '{1, 0}, '{3, 0}, '{REJ, 0}, '{REJ + 1, 0}, '{ACC - 1, 0},
    '{ACC, 1}, '{ACC + 1, 1}, '{20, 1}, '{40, 1}
  };

  logic clk = 1'b0;
  logic rst;
  logic lineIn;
  logic present;

  int testsRun   = 0;
  int testsFailed = 0;
  bit finished   = 1'b0;

  always #2 clk = ~clk;

  activity_qualifier #(
    .SYNC_STAGES(SYNC),
    .REJECT_W   (REJ),
    .ACCEPT_W   (ACC),
    .RELEASE_W  (REL),
    .HOLDOFF_W  (HOLD)
  ) i_activity_qualifier (
    .clk    (clk),
    .rst    (rst),
    .lineIn (lineIn),
    .present(present)
  );

  task automatic chk(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    lineIn = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Drive lineIn per edge from up to three segments; record first two rises/falls
  task automatic runPattern(input int s0, input int l0, input int s1, input int l1,
                            input int s2, input int l2, input int nEdges,
                            output int r1, output int f1, output int r2, output int f2);
    logic prevP;
    r1 = -1; f1 = -1; r2 = -1; f2 = -1;
    prevP = present;
    for (int n = 1; n <= nEdges; n++) begin
      lineIn = ((n >= s0) && (n < s0 + l0)) || ((n >= s1) && (n < s1 + l1)) ||
               ((n >= s2) && (n < s2 + l2));
      @(posedge clk);
      @(negedge clk);
      if (present && !prevP) begin
        if (r1 < 0) r1 = n; else if (r2 < 0) r2 = n;
      end
      if (!present && prevP) begin
        if (f1 < 0) f1 = n; else if (f2 < 0) f2 = n;
      end
      prevP = present;
    end
    lineIn = 1'b0;
  endtask

  initial begin
    #200us;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int r1, f1, r2, f2;
    int everHigh;

    // R1: reset held with line active keeps present low
    rst = 1'b1;
    lineIn = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 present during reset", int'(present), 0);
    lineIn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    idle(5);
    chk("R1 present after reset", int'(present), 0);

    // R3/R4/R5: table of single pulses
    for (int v = 0; v < NVEC; v++) begin
      runPattern(1, VEC[v][0], 0, 0, 0, 0, 80, r1, f1, r2, f2);
      if (VEC[v][1] != 0) begin
        chk($sformatf("R4 rise edge w=%0d", VEC[v][0]), r1, RISE_N);
        chk($sformatf("R5 fall edge w=%0d", VEC[v][0]), f1, FALL_N);
      end else begin
        chk($sformatf("R3 no assertion w=%0d", VEC[v][0]), r1, -1);
      end
      idle(60);
    end

    // R2: long idle keeps present low
    everHigh = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (present) everHigh = 1;
    end
    chk("R2 idle low", everHigh, 0);

    // R5: retriggers by qualifying runs extend presence
    runPattern(1, ACC, 20, REJ + 1, 35, REJ + 1, 100, r1, f1, r2, f2);
    chk("R5 retrigger rise", r1, RISE_N);
    chk("R5 retrigger fall", f1, 35 + REJ + SYNC - 1 + REL);
    idle(60);

    // R5: run of exactly REJECT_W samples restarts the timer
    runPattern(1, ACC, 20, REJ, 0, 0, 100, r1, f1, r2, f2);
    chk("R5 reject-width retrigger fall", f1, 20 + REJ + SYNC - 1 + REL);
    idle(60);

    // R6: glitch shorter than REJECT_W does not extend
    runPattern(1, ACC, 20, REJ - 1, 0, 0, 100, r1, f1, r2, f2);
    chk("R6 glitch no extend", f1, FALL_N);
    idle(60);

    // R7: qualified run wholly inside hold-off does not assert
    runPattern(1, ACC, FALL_N + 1, ACC + 1, 0, 0, 120, r1, f1, r2, f2);
    chk("R7 first fall", f1, FALL_N);
    chk("R7 blocked in hold-off", r2, -1);
    idle(60);

    // R8: run held across hold-off asserts at the first permitted edge
    runPattern(1, ACC, FALL_N + 1, 40, 0, 0, 120, r1, f1, r2, f2);
    chk("R8 rise after hold-off", r2, FALL_N + HOLD + 1);
    chk("R8 second fall", f2, FALL_N + HOLD + 1 + REL);
    idle(60);

    // R1: reset during presence, then no stale hold-off
    lineIn = 1'b1;
    repeat (RISE_N) begin
      @(posedge clk);
      @(negedge clk);
    end
    chk("R4 manual rise", int'(present), 1);
    rst = 1'b1;
    lineIn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 reset clears present", int'(present), 0);
    rst = 1'b0;
    runPattern(1, ACC, 0, 0, 0, 0, 80, r1, f1, r2, f2);
    chk("R1 no stale hold-off rise", r1, RISE_N);
    chk("R1 no stale hold-off fall", f1, FALL_N);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    finished = 1'b1;
    $finish;
  end

endmodule